// File: doc/BRIEF.md
# Dual-Array March Test Controller

This block runs a March C- memory test on two identical memory arrays at once. Both arrays share one address, one write data word and one pair of read and write strobes. The block never computes an expected read value. Instead it compares the two arrays' read data word for word, and any disagreement marks a fault in one of them.

Addresses come from a bidirectional shift-register generator. Its feedback includes the all-zero state, so it walks all 2^ADDR_W locations. Ascending elements step the register forward. Descending elements step the exact inverse function, so they visit the same locations in the reverse order. Both directions start at the same seed. The test begins on a rising edge of `start`. `done` pulses once after the last read has been compared. `err` holds any detected mismatch until the next test begins.

Top module: `march_bist_ctrl`

## Requirements
- R1: After reset, `done`, `err`, `mem_we` and `mem_re` are all low. No memory operation happens until a rising edge of `start` is seen while the block is idle.
- R2: Every March element visits each of the 2^ADDR_W addresses exactly once. Each element begins at the seed address SEED (default 1).
- R3: In the two descending elements (the 4th and 5th), the k-th address visited equals the ((2^ADDR_W - k) mod 2^ADDR_W)-th address of the ascending elements.
- R4: The elements run in this order: write 0; read, write 1; read, write 0; read, write 1 (descending); read, write 0 (descending); read. In two-operation elements, the read of an address comes in the cycle right before its write to the same address. Write data is all zeros or all ones, as the element demands.
- R5: `mem_we` and `mem_re` are never high in the same cycle. Exactly one operation is issued per running cycle, for 10 x 2^ADDR_W operations in total.
- R6: A single read beat where `rd_data_a` differs from `rd_data_b` raises `err`. Once raised, `err` stays high through the end of the test and while idle.
- R7: When both arrays always return the same data, `err` stays low for the whole test.
- R8: `done` is high for exactly one cycle, two cycles after the last operation, with both strobes low.
- R9: Rising edges of `start` while a test is running are ignored. The running test neither restarts nor lengthens.
- R10: An accepted start clears `err` before the first operation of the new test.
- R11: The read data is compared only in the cycle after `mem_re`. Disagreement in any other cycle has no effect on `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | A rising edge starts a test when idle |
| done | output | 1 | One-cycle pulse when the test is complete |
| err | output | 1 | Sticky flag: the two arrays disagreed |
| mem_addr | output | ADDR_W | Address shared by both arrays |
| mem_wdata | output | DATA_W | Write data shared by both arrays |
| mem_we | output | 1 | Write strobe for both arrays |
| mem_re | output | 1 | Read strobe for both arrays; data is returned one cycle later |
| rd_data_a | input | DATA_W | Read data from array A |
| rd_data_b | input | DATA_W | Read data from array B |

## Verification
Fault-free arrays show that the comparator stays quiet (R7). Random single-cell stuck-at faults of both polarities show that both the r0 and the r1 reads catch a bad cell. One-beat read corruptions at the first and last read, and at random read positions, show that a single mismatch is latched and held. Read data that disagrees only outside the valid-data cycle separates a correctly timed comparator from one that samples too early, too late or every cycle. Extra start pulses in the middle of a run, and a clean run right after a failing one, separate edge-qualified start handling and error clearing from level-sensitive handling.

// File: rtl/march_pkg.sv
package march_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } bist_st_t;

   localparam int NUM_ELEM = 6;
   localparam int ELEM_W   = 3;

   // feedback taps (bits 1..7) of a maximal-length shift-right register
   function automatic logic [7:0] lfsr_taps(input int w);
      case (w)
         5:       return 8'b0000_0100;
         8:       return 8'b0001_1100;
         default: return 8'b0000_0010;
      endcase
   endfunction

   // March C- element table
   function automatic logic elem_single(input logic [ELEM_W-1:0] e);
      return (e == 3'd0) || (e == 3'd5);
   endfunction

   function automatic logic elem_rev(input logic [ELEM_W-1:0] e);
      return (e == 3'd3) || (e == 3'd4);
   endfunction

   function automatic logic elem_wval(input logic [ELEM_W-1:0] e);
      return (e == 3'd1) || (e == 3'd3);
   endfunction

endpackage

// File: rtl/march_lfsr.sv
module march_lfsr #(
   parameter int ADDR_W = 4,
   parameter int SEED   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              rev,
   output logic [ADDR_W-1:0] addr
);
   import march_pkg::*;

   localparam logic [7:0]        TAPS8 = lfsr_taps(ADDR_W);
   localparam logic [ADDR_W-1:0] TAPS  = TAPS8[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] SEED_V = ADDR_W'(SEED);

   logic [ADDR_W-1:0] st_q;
   logic [ADDR_W-1:0] nxt_fwd, nxt_rev;
   logic [ADDR_W-2:0] hi_f, hi_r;
   logic              fb_f, b0_r;

   always_comb begin
      // forward: new MSB from feedback, zero state spliced in after 0..01
      hi_f    = st_q[ADDR_W-1:1];
      fb_f    = st_q[0] ^ (^(st_q & TAPS)) ^ (hi_f == '0);
      nxt_fwd = {fb_f, hi_f};
      // inverse: rebuild the bit shifted out from the MSB that was fed back
      hi_r    = st_q[ADDR_W-2:0];
      b0_r    = st_q[ADDR_W-1] ^ (^({hi_r, 1'b0} & TAPS)) ^ (hi_r == '0);
      nxt_rev = {hi_r, b0_r};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= SEED_V;
      else if (load) st_q <= SEED_V;
      else if (step) st_q <= rev ? nxt_rev : nxt_fwd;
   end

   assign addr = st_q;

endmodule

// File: rtl/march_seq.sv
module march_seq #(
   parameter int ADDR_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic lf_load,
   output logic lf_step,
   output logic lf_rev,
   output logic we,
   output logic re,
   output logic wval,
   output logic cmp_clr,
   output logic done
);
   import march_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_CNT = '1;

   bist_st_t          st_q;
   logic [ELEM_W-1:0] elem_q;
   logic              op_q;
   logic [ADDR_W-1:0] cnt_q;
   logic              start_q, done_q;

   logic running, go, single, op_last, addr_last, is_wr;

   always_comb begin
      running   = (st_q == ST_RUN);
      go        = start && !start_q && (st_q == ST_IDLE);
      single    = elem_single(elem_q);
      op_last   = single ? 1'b1 : op_q;
      addr_last = (cnt_q == LAST_CNT);
      is_wr     = single ? (elem_q == 3'd0) : op_q;
      we        = running && is_wr;
      re        = running && !is_wr;
      wval      = elem_wval(elem_q);
      lf_rev    = elem_rev(elem_q);
      lf_load   = go || (running && op_last && addr_last);
      lf_step   = running && op_last && !addr_last;
      cmp_clr   = go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         elem_q  <= '0;
         op_q    <= 1'b0;
         cnt_q   <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         start_q <= start;
         done_q  <= (st_q == ST_DRAIN);
         case (st_q)
            ST_IDLE: if (go) begin
               st_q   <= ST_RUN;
               elem_q <= '0;
               op_q   <= 1'b0;
               cnt_q  <= '0;
            end
            ST_RUN: begin
               if (!op_last) begin
                  op_q <= 1'b1;
               end else begin
                  op_q <= 1'b0;
                  if (addr_last) begin
                     cnt_q <= '0;
                     if (elem_q == ELEM_W'(NUM_ELEM - 1)) st_q <= ST_DRAIN;
                     else                                  elem_q <= elem_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done = done_q;

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              re,
   input  logic [DATA_W-1:0] rd_a,
   input  logic [DATA_W-1:0] rd_b,
   output logic              err
);
   logic rv_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         rv_q <= re;
         if (clr)                      err_q <= 1'b0;
         else if (rv_q && rd_a != rd_b) err_q <= 1'b1;
      end
   end

   assign err = err_q;

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int SEED   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] rd_data_a,
   input  logic [DATA_W-1:0] rd_data_b
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
         $error("march_bist_ctrl: ADDR_W must lie in 2..8");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("march_bist_ctrl: DATA_W must be positive");
      end
      if (SEED < 0 || SEED >= DEPTH) begin : g_bad_seed
         $error("march_bist_ctrl: SEED out of address range");
      end
   endgenerate

   logic lf_load, lf_step, lf_rev, wval, cmp_clr;

   march_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .lf_load(lf_load), .lf_step(lf_step), .lf_rev(lf_rev),
      .we(mem_we), .re(mem_re), .wval(wval),
      .cmp_clr(cmp_clr), .done(done)
   );

   march_lfsr #(.ADDR_W(ADDR_W), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n),
      .load(lf_load), .step(lf_step), .rev(lf_rev),
      .addr(mem_addr)
   );

   // data writer: solid background of the element's write value
   assign mem_wdata = {DATA_W{wval}};

   march_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .re(mem_re),
      .rd_a(rd_data_a), .rd_b(rd_data_b), .err(err)
   );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              mem_re,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] rd_data_b
);
   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_solid_wdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_we && !mem_re));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($past(mem_re, 2) && ($past(rd_data_a) != $past(rd_data_b))));

endmodule

bind march_bist_ctrl march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
   .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/tb_march_bist_ctrl.sv
`timescale 1ns/1ps
module tb_march_bist_ctrl;
   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int SEEDV = 1;
   localparam int DEPTH = 1 << AW;
   localparam int NOPS  = 10 * DEPTH;
   localparam int NRD   = 5 * DEPTH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, err, we, re;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rd_a, rd_b;

   always #2 clk = ~clk;

   march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SEED(SEEDV)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
      .mem_addr(addr), .mem_wdata(wdata), .mem_we(we), .mem_re(re),
      .rd_data_a(rd_a), .rd_data_b(rd_b)
   );

   // two behavioural synchronous-read arrays with fault hooks on B
   logic [DW-1:0] mem_a [DEPTH];
   logic [DW-1:0] mem_b [DEPTH];
   logic [DW-1:0] rd_a_q = '0, rd_b_q = '0;
   logic          rv_q = 1'b0;
   int            rcnt = 0;
   bit f_en = 0, f_val = 0, t_en = 0, lat_mode = 0;
   int f_addr = 0, f_bit = 0, t_idx = 0;

   always @(posedge clk) begin
      logic [DW-1:0] v;
      if (we) begin
         mem_a[addr] <= wdata;
         mem_b[addr] <= wdata;
      end
      rv_q <= re;
      if (re) begin
         rd_a_q <= mem_a[addr];
         v = mem_b[addr];
         if (f_en && int'(addr) == f_addr) v[f_bit] = f_val;
         if (t_en && rcnt == t_idx) v = v ^ 8'h01;
         rd_b_q <= v;
         rcnt <= rcnt + 1;
      end
   end

   assign rd_a = rd_a_q;
   assign rd_b = lat_mode ? (rv_q ? rd_b_q : ~rd_a_q) : rd_b_q;

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // trace of issued operations
   int  l_addr [512];
   bit  l_we [512];
   bit  l_re [512];
   int  l_wd [512];
   int  nops, ndone, both, last_op, last_done, ops_after_done;
   bit  err_done, err_late, err_first;

   function automatic int elem_n(input int e);
      return (e == 0 || e == 5) ? DEPTH : 2 * DEPTH;
   endfunction
   function automatic int elem_base(input int e);
      int b = 0;
      for (int i = 0; i < e; i++) b += elem_n(i);
      return b;
   endfunction
   function automatic int loc_idx(input int e, input int k);
      return elem_base(e) + ((elem_n(e) == DEPTH) ? k : 2 * k);
   endfunction
   function automatic int exp_wval(input int e);
      return (e == 1 || e == 3) ? 255 : 0;
   endfunction

   task automatic run_test(input bit extra_start);
      nops = 0; ndone = 0; both = 0; last_op = -1; last_done = -1;
      ops_after_done = 0; err_first = 1'b0;
      rcnt = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int c = 0; c < NOPS + 30; c++) begin
         if (extra_start && c == 37) start = 1'b1;
         if (extra_start && c == 41) start = 1'b0;
         if (extra_start && c == 90) start = 1'b1;
         if (extra_start && c == 91) start = 1'b0;
         if (c == 0) err_first = err;
         if (we && re) both++;
         if (we || re) begin
            if (ndone > 0) ops_after_done++;
            l_addr[nops] = int'(addr); l_we[nops] = we; l_re[nops] = re;
            l_wd[nops] = int'(wdata);
            nops++; last_op = c;
         end
         if (done) begin
            ndone++; last_done = c; err_done = err;
            if (we || re) both++;
         end
         @(negedge clk);
      end
      err_late = err;
   endtask

   task automatic analyze_trace(input string tag);
      int bad_r4, bad_r2, bad_r3, bad_seed;
      bad_r4 = 0; bad_r2 = 0; bad_r3 = 0; bad_seed = 0;
      check(nops == NOPS, {"R5 op count ", tag}, nops, NOPS);
      check(both == 0, {"R5 strobe overlap ", tag}, both, 0);
      check(ndone == 1 && ops_after_done == 0, {"R8 done once ", tag}, ndone, 1);
      check(last_done - last_op == 2, {"R8 done delay ", tag}, last_done - last_op, 2);
      if (nops != NOPS) return;
      for (int e = 0; e < 6; e++) begin
         logic [DEPTH-1:0] seen = '0;
         for (int k = 0; k < DEPTH; k++) begin
            int i = loc_idx(e, k);
            seen[l_addr[i]] = 1'b1;
            if (e == 0) begin
               if (!l_we[i] || l_wd[i] != 0) bad_r4++;
            end else if (e == 5) begin
               if (!l_re[i]) bad_r4++;
            end else begin
               if (!l_re[i] || !l_we[i+1] || l_addr[i+1] != l_addr[i] ||
                   l_wd[i+1] != exp_wval(e)) bad_r4++;
            end
         end
         if (seen != '1) bad_r2++;
         if (l_addr[loc_idx(e, 0)] != SEEDV) bad_seed++;
      end
      for (int k = 0; k < DEPTH; k++) begin
         int up = l_addr[loc_idx(1, (DEPTH - k) % DEPTH)];
         if (l_addr[loc_idx(3, k)] != up || l_addr[loc_idx(4, k)] != up) bad_r3++;
         if (l_addr[loc_idx(0, k)] != l_addr[loc_idx(1, k)] ||
             l_addr[loc_idx(2, k)] != l_addr[loc_idx(1, k)] ||
             l_addr[loc_idx(5, k)] != l_addr[loc_idx(1, k)]) bad_r3++;
      end
      check(bad_r4 == 0, {"R4 element ops ", tag}, bad_r4, 0);
      check(bad_r2 == 0, {"R2 full coverage ", tag}, bad_r2, 0);
      check(bad_seed == 0, {"R2 seed start ", tag}, bad_seed, 0);
      check(bad_r3 == 0, {"R3 reverse order ", tag}, bad_r3, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'd1913);
      for (int i = 0; i < DEPTH; i++) begin mem_a[i] = '0; mem_b[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!done && !err && !we && !re, "R1 reset outputs", {done, err, we, re}, 0);
      rst_n = 1'b1;
      begin
         int act = 0;
         for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (we || re || done || err) act++;
         end
         check(act == 0, "R1 idle without start", act, 0);
      end

      // R7: clean arrays
      run_test(1'b0);
      analyze_trace("clean");
      check(!err_done && !err_late, "R7 no error on clean run", err_done, 0);

      // R6: directed and random stuck-at cells
      for (int n = 0; n < 6; n++) begin
         f_en = 1; f_addr = (n == 0) ? SEEDV : (n == 1) ? 0 : int'($urandom_range(DEPTH - 1));
         f_bit = int'($urandom_range(DW - 1)); f_val = n[0];
         run_test(1'b0);
         check(err_done, $sformatf("R6 stuck-at cell %0d bit %0d val %0d", f_addr, f_bit, f_val),
               err_done, 1);
         check(err_late, "R6 error held after done", err_late, 1);
      end
      f_en = 0;

      // R10: clean run after a failing one clears the flag
      run_test(1'b0);
      check(!err_first, "R10 error cleared at start", err_first, 0);
      check(!err_done, "R10 clean run after fail", err_done, 0);

      // R6: one-beat corruption, first, last and random read
      for (int n = 0; n < 4; n++) begin
         t_en = 1; t_idx = (n == 0) ? 0 : (n == 1) ? NRD - 1 : int'($urandom_range(NRD - 1));
         run_test(1'b0);
         check(err_done && err_late, $sformatf("R6 single bad read %0d", t_idx), err_done, 1);
      end
      t_en = 0;

      // R9: start edges during a run
      run_test(1'b1);
      analyze_trace("restart-ignored");
      check(!err_done, "R9 clean with extra start", err_done, 0);

      // R11: disagreement only outside the valid-data cycle
      lat_mode = 1;
      run_test(1'b0);
      check(!err_done && !err_late, "R11 compare only after read", err_done, 0);
      lat_mode = 0;

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule